// File: doc/BRIEF.md
# Banked Four-Reader Register File

This block is a 256-word register file that behaves, towards four functional units, like a file with four read ports, though it is built from eight storage banks of 32 words with only one read port and one write port each. A register number selects its bank with its low three bits, so registers with neighbouring numbers sit in different banks and a unit group that walks through consecutive registers reads them all in one cycle.

Each cycle the block examines the pending read requests. It serves every bank that is asked for. When several units ask for the same register, one bank read is shared among all of them. When units ask for different registers that live in one bank, they are taken one per cycle, the lowest-numbered unit first. Requests are grouped: the requests present when the block is idle form a group, and no new request is taken until every member of that group has been served.

Reads use a valid/ready handshake per unit. A unit raises its request valid with a register number and holds both until it sees ready. Ready is the grant. In that same cycle the response valid rises and the data is on the response bus. The response cannot be stalled: there is no ready on the response side, and the unit must take the data in the cycle it appears. One write port updates a register at the clock edge.

Top module: `banked_rf`

## Requirements
- R1: After reset every register reads as zero, and with no request present no ready or response valid is raised. A response data lane whose valid is low reads zero.
- R2: A register number selects its bank with bits [2:0] and its word in that bank with bits [7:3]. Four requests to four different banks are all granted in the same cycle.
- R3: When two or more units request the same register, all of them are granted in the same cycle and receive the same data.
- R4: Requests for different registers in the same bank are granted one per cycle, in order of increasing unit index.
- R5: A unit's ready and response valid are raised together, only while its request valid is high, and the response data in that cycle is the register's current content.
- R6: A unit holds its request valid and register number until it sees ready. While a group is still being served, a unit that has already been served and raises a new request is not granted until the group is finished.
- R7: A write updates the register at the clock edge. A read of that register in the same cycle returns the old value, and a read in a later cycle returns the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | NUM_UNITS | Read request valid, one bit per unit |
| rd_req_addr | input | NUM_UNITS x ADDR_W | Register number per unit |
| rd_req_ready | output | NUM_UNITS | Grant per unit; the request is consumed |
| rd_rsp_valid | output | NUM_UNITS | Response valid per unit, same cycle as ready |
| rd_rsp_data | output | NUM_UNITS x DATA_W | Read data per unit, zero when not valid |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Register number to write |
| wr_data | input | DATA_W | Write data |

## Verification
The two functions that meet in one cycle are broadcast of a shared register and serialisation of a genuine bank conflict: a group where two units name one register while a third names another word of that same bank must grant the pair together and the third one cycle later. The bench provokes this in directed groups and in many random groups drawn from a narrow address range, and it also lands a write on a register in the very cycle it is read. A behavioural model holding the register contents and the set of unserved units predicts every grant and every data word, and it is compared with the ports on each clock.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic {
    GRP_IDLE  = 1'b0,
    GRP_DRAIN = 1'b1
  } grp_state_e;

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 32,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wword,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [WORD_W-1:0] rword,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else if (we) begin
      store[wword] <= wdata;
    end
  end

  // single read port: old contents until the edge that writes
  assign rdata = re ? store[rword] : '0;

endmodule

// File: rtl/rf_conflict_arb.sv
module rf_conflict_arb #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 8,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int WORD_W    = ADDR_W - BANK_BITS
) (
  input  logic [NUM_UNITS-1:0]              member,
  input  logic [NUM_UNITS-1:0][ADDR_W-1:0]  addr,
  output logic [NUM_UNITS-1:0]              grant,
  output logic [NUM_BANKS-1:0]              bank_re,
  output logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_rword
);

  logic [NUM_BANKS-1:0] claimed;

  // lowest unit claims its bank; later units sharing the word ride along
  always_comb begin
    claimed    = '0;
    bank_rword = '0;
    grant      = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (member[u]) begin
        if (!claimed[addr[u][BANK_BITS-1:0]]) begin
          claimed[addr[u][BANK_BITS-1:0]]    = 1'b1;
          bank_rword[addr[u][BANK_BITS-1:0]] = addr[u][ADDR_W-1:BANK_BITS];
          grant[u] = 1'b1;
        end else if (bank_rword[addr[u][BANK_BITS-1:0]] == addr[u][ADDR_W-1:BANK_BITS]) begin
          grant[u] = 1'b1;
        end
      end
    end
  end

  assign bank_re = claimed;

endmodule

// File: rtl/rf_group_ctrl.sv
module rf_group_ctrl
  import banked_rf_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_UNITS-1:0] req_valid,
  input  logic [NUM_UNITS-1:0] grant,
  output logic [NUM_UNITS-1:0] member,
  output logic                 busy
);

  grp_state_e           state_q;
  logic [NUM_UNITS-1:0] left_q;
  logic [NUM_UNITS-1:0] remain;

  assign member = (state_q == GRP_IDLE) ? req_valid : (left_q & req_valid);
  assign remain = member & ~grant;
  assign busy   = (state_q == GRP_DRAIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GRP_IDLE;
      left_q  <= '0;
    end else if (|remain) begin
      state_q <= GRP_DRAIN;
      left_q  <= remain;
    end else begin
      state_q <= GRP_IDLE;
      left_q  <= '0;
    end
  end

endmodule

// File: rtl/banked_rf.sv
module banked_rf #(
  parameter int NUM_UNITS  = 4,
  parameter int NUM_BANKS  = 8,
  parameter int BANK_WORDS = 32,
  parameter int DATA_W     = 32,
  localparam int ADDR_W    = $clog2(NUM_BANKS * BANK_WORDS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_UNITS-1:0]               rd_req_valid,
  input  logic [NUM_UNITS-1:0][ADDR_W-1:0]   rd_req_addr,
  output logic [NUM_UNITS-1:0]               rd_req_ready,
  output logic [NUM_UNITS-1:0]               rd_rsp_valid,
  output logic [NUM_UNITS-1:0][DATA_W-1:0]   rd_rsp_data,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data
);

  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int WORD_W    = ADDR_W - BANK_BITS;

  logic [NUM_UNITS-1:0]             member;
  logic [NUM_UNITS-1:0]             grant;
  logic                             batch_busy;
  logic [NUM_BANKS-1:0]             bank_re;
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_rword;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;

  rf_group_ctrl #(.NUM_UNITS(NUM_UNITS)) u_grp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (rd_req_valid),
    .grant     (grant),
    .member    (member),
    .busy      (batch_busy)
  );

  rf_conflict_arb #(
    .NUM_UNITS (NUM_UNITS),
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_arb (
    .member     (member),
    .addr       (rd_req_addr),
    .grant      (grant),
    .bank_re    (bank_re),
    .bank_rword (bank_rword)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_addr[BANK_BITS-1:0] == BANK_BITS'(b));
    rf_bank #(.WORDS(BANK_WORDS), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we),
      .wword (wr_addr[ADDR_W-1:BANK_BITS]),
      .wdata (wr_data),
      .re    (bank_re[b]),
      .rword (bank_rword[b]),
      .rdata (bank_rdata[b])
    );
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign rd_rsp_data[u] = grant[u] ? bank_rdata[rd_req_addr[u][BANK_BITS-1:0]] : '0;
  end

  assign rd_req_ready = grant;
  assign rd_rsp_valid = grant;

endmodule

// File: rtl/banked_rf_chk.sv
module banked_rf_chk #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_UNITS-1:0]             rd_req_valid,
  input logic [NUM_UNITS-1:0][ADDR_W-1:0] rd_req_addr,
  input logic [NUM_UNITS-1:0]             rd_req_ready,
  input logic [NUM_UNITS-1:0]             rd_rsp_valid,
  input logic [NUM_UNITS-1:0][DATA_W-1:0] rd_rsp_data,
  input logic                             batch_busy
);

  localparam int BANK_BITS = $clog2(NUM_BANKS);

  AST_FIRST_UNIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!batch_busy && rd_req_valid[0]) |-> rd_req_ready[0]); // R4

  AST_SOME_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_req_valid) |-> (|rd_req_ready)); // R6

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_ready[u] || rd_rsp_valid[u]) |-> rd_req_valid[u]); // R5

    AST_QUIET_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_rsp_valid[u] |-> (rd_rsp_data[u] == '0)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid[u] && !rd_req_ready[u]) |=> (rd_req_valid[u] && $stable(rd_req_addr[u]))); // R6

    for (genvar v = u + 1; v < NUM_UNITS; v++) begin : g_v
      AST_ONE_WORD_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_ready[u] && rd_req_ready[v] &&
         rd_req_addr[u][BANK_BITS-1:0] == rd_req_addr[v][BANK_BITS-1:0])
        |-> (rd_req_addr[u] == rd_req_addr[v])); // R4

      AST_SHARED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rsp_valid[u] && rd_rsp_valid[v] && rd_req_addr[u] == rd_req_addr[v])
        |-> (rd_rsp_data[u] == rd_rsp_data[v])); // R3
    end
  end

endmodule

bind banked_rf banked_rf_chk #(
  .NUM_UNITS (NUM_UNITS),
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_addr  (rd_req_addr),
  .rd_req_ready (rd_req_ready),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_data  (rd_rsp_data),
  .batch_busy   (batch_busy)
);

// File: tb/banked_rf_bench.sv
module banked_rf_bench;

  localparam int NU = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NU-1:0]        req_valid = '0;
  logic [NU-1:0][AW-1:0] req_addr = '0;
  logic [NU-1:0]        req_ready;
  logic [NU-1:0]        rsp_valid;
  logic [NU-1:0][DW-1:0] rsp_data;
  logic                 wr_en = 1'b0;
  logic [AW-1:0]        wr_addr = '0;
  logic [DW-1:0]        wr_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  banked_rf u_banked_rf (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_valid (req_valid),
    .rd_req_addr  (req_addr),
    .rd_req_ready (req_ready),
    .rd_rsp_valid (rsp_valid),
    .rd_rsp_data  (rsp_data),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data)
  );

  // behavioural reference: register contents and unserved units of the group
  logic [DW-1:0] m_mem [256];
  bit            m_busy;
  bit [NU-1:0]   m_left;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = '0;
      m_busy = 0;
      m_left = '0;
    end else begin
      bit [NU-1:0] mem_set;
      bit [NU-1:0] exp_g;
      mem_set = m_busy ? (m_left & req_valid) : req_valid;
      exp_g = '0;
      for (int u = 0; u < NU; u++) begin
        if (mem_set[u]) begin
          int first;
          first = -1;
          for (int j = 0; j < u && first < 0; j++)
            if (mem_set[j] && req_addr[j][2:0] == req_addr[u][2:0]) first = j;
          if (first < 0 || req_addr[first] == req_addr[u]) exp_g[u] = 1;
        end
      end
      check(req_ready == exp_g, "R4 grant set", req_ready, exp_g);
      check(rsp_valid == exp_g, "R5 response valid", rsp_valid, exp_g);
      for (int u = 0; u < NU; u++) begin
        logic [DW-1:0] ed;
        ed = exp_g[u] ? m_mem[req_addr[u]] : '0;
        check(rsp_data[u] == ed, "R7 response data", rsp_data[u], ed);
      end
      m_left = mem_set & ~exp_g;
      m_busy = |m_left;
      if (wr_en) m_mem[wr_addr] = wr_data;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [NU-1:0] glog [8];
  logic [DW-1:0] dlog [8][NU];

  // present a group, drop each unit once granted; optional write in first cycle
  task automatic run_group(input logic [NU-1:0] mask, input logic [NU-1:0][AW-1:0] a,
                           input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                           output int ncyc);
    logic [NU-1:0] pend;
    @(posedge clk); #1;
    req_valid = mask; req_addr = a;
    wr_en = we; wr_addr = wa; wr_data = wd;
    pend = mask; ncyc = 0;
    while (pend != '0 && ncyc < 8) begin
      @(negedge clk);
      glog[ncyc] = req_ready;
      for (int u = 0; u < NU; u++) dlog[ncyc][u] = rsp_data[u];
      pend &= ~req_ready;
      ncyc++;
      @(posedge clk); #1;
      req_valid = pend;
      wr_en = 0;
    end
  endtask

  initial begin
    int n;
    logic [NU-1:0][AW-1:0] a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: quiet after reset, registers read zero
    @(negedge clk);
    check(req_ready == '0 && rsp_valid == '0, "R1 idle outputs", {req_ready, rsp_valid}, 0);
    a = {8'd203, 8'd130, 8'd77, 8'd0};
    run_group(4'hF, a, 0, 0, 0, n);
    check(dlog[0][0] == 0 && dlog[0][1] == 0 && dlog[0][2] == 0 && dlog[0][3] == 0,
          "R1 reset contents", dlog[0][3], 0);

    // R7: write and read same register in one cycle
    a = {8'd0, 8'd0, 8'd0, 8'd9};
    run_group(4'h1, a, 1, 8'd9, 32'hA5A5_0009, n);
    check(dlog[0][0] == 0, "R7 old value same cycle", dlog[0][0], 0);
    run_group(4'h1, a, 0, 0, 0, n);
    check(dlog[0][0] == 32'hA5A5_0009, "R7 new value later", dlog[0][0], 32'hA5A5_0009);

    // fill a few registers with distinct values
    for (int r = 16; r < 20; r++) run_group(4'h0, a, 1, AW'(r), DW'(32'h100 + r), n);
    for (int r = 0; r < 32; r += 8) run_group(4'h0, a, 1, AW'(r), DW'(32'h200 + r), n);
    run_group(4'h0, a, 1, 8'd1, 32'h301, n);

    // R2: four consecutive registers in one cycle
    a = {8'd19, 8'd18, 8'd17, 8'd16};
    run_group(4'hF, a, 0, 0, 0, n);
    check(n == 1 && glog[0] == 4'hF, "R2 consecutive parallel", n, 1);
    check(dlog[0][2] == 32'h112, "R2 bank and word mapping", dlog[0][2], 32'h112);

    // R3: all four units on one register
    a = {8'd17, 8'd17, 8'd17, 8'd17};
    run_group(4'hF, a, 0, 0, 0, n);
    check(n == 1 && glog[0] == 4'hF, "R3 broadcast one cycle", n, 1);
    check(dlog[0][3] == 32'h111 && dlog[0][0] == 32'h111, "R3 broadcast data", dlog[0][3], 32'h111);

    // R4: four words of bank 0, served in unit order
    a = {8'd24, 8'd16, 8'd8, 8'd0};
    run_group(4'hF, a, 0, 0, 0, n);
    check(n == 4, "R4 serial cycles", n, 4);
    check(glog[0] == 4'h1 && glog[1] == 4'h2 && glog[2] == 4'h4 && glog[3] == 4'h8,
          "R4 priority order", {glog[0], glog[1], glog[2], glog[3]}, 16'h1248);
    check(dlog[3][3] == 32'h218, "R4 last data", dlog[3][3], 32'h218);

    // R3 with R4: pair shares reg 8, unit 2 conflicts in bank 0, unit 3 elsewhere
    a = {8'd1, 8'd16, 8'd8, 8'd8};
    run_group(4'hF, a, 0, 0, 0, n);
    check(n == 2 && glog[0] == 4'hB && glog[1] == 4'h4, "R3 broadcast with conflict",
          {glog[0], glog[1]}, 8'hB4);
    check(dlog[0][3] == 32'h301 && dlog[1][2] == 32'h210, "R4 mixed data", dlog[1][2], 32'h210);

    // R6: served unit re-requests during a group
    @(posedge clk); #1;
    req_valid = 4'h3; req_addr = {8'd0, 8'd0, 8'd8, 8'd0};
    @(negedge clk);
    check(req_ready == 4'h1, "R6 first grant", req_ready, 4'h1);
    @(posedge clk); #1;
    req_addr[0] = 8'd1;
    @(negedge clk);
    check(req_ready == 4'h2, "R6 new request held back", req_ready, 4'h2);
    @(posedge clk); #1;
    req_valid = 4'h1;
    @(negedge clk);
    check(req_ready == 4'h1 && rsp_data[0] == 32'h301, "R6 new request after group",
          rsp_data[0], 32'h301);
    @(posedge clk); #1;
    req_valid = '0;

    // random groups over a narrow range; model compares every cycle
    for (int k = 0; k < 400; k++) begin
      for (int u = 0; u < NU; u++) a[u] = AW'($urandom_range(0, 31));
      run_group(NU'($urandom_range(1, 15)), a, 1'($urandom_range(0, 1)),
                AW'($urandom_range(0, 31)), $urandom, n);
    end

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule